// File: doc/BRIEF.md
# Configuration Byte-Stream Loader

This block brings a device up from an external configuration memory. After a reset, or when the command controller asks for a reload, it reads the memory one byte at a time through a simple request/acknowledge port. The first byte must hold a fixed signature (A5h). A memory without it is taken to be blank, and nothing is loaded. When the signature is present, the next byte gives a count N, and the N bytes after it are sent out as configuration writes. Each write carries a target address that starts at zero and goes up by one.

While a load is running, the device-ready output stays low. A load can end in four ways: it succeeds, the signature is wrong, the memory reports an error or timeout, or the record runs past the last memory location. In every case ready rises again and a one-cycle done pulse tells the command controller the operation is over.

Two status bits describe the result. The loaded bit is set only by a successful load. The overflow bit is set when the record would need a byte beyond the last memory address. It stays set until the next reload starts or the block is reset.

Top module: `cfg_loader`

## Requirements
- R1: A load starts on the first clock after reset is released, and on `start_i` when the block is idle. `ready_o` is low from reset or from the accepted start until the load ends. At the end, `ready_o` rises and `done_o` pulses high for one cycle on the same clock edge.
- R2: Memory reads go out one at a time, each as a one-cycle `rd_req_o` pulse. A new read is issued only after `rd_ack_i` returns the previous one. Within a load, addresses run 0, 1, 2 and so on.
- R3: If the byte at address 0 is not A5h, the load fails after that single read. It makes no configuration writes and leaves `loaded_o` at 0.
- R4: After a valid signature, the byte at address 1 is the count N. The bytes at addresses 2 to N+1 are written out in order, one `cfg_we_o` pulse each, with `cfg_addr_o` going 0 to N-1 and `cfg_data_o` equal to the byte read.
- R5: `loaded_o` is cleared when a load starts. It is set only when all N bytes have been written without error.
- R6: If a load needs a byte at an address of `MEM_BYTES` or above, no read is issued for it, `overflow_o` is set and the load fails. Bytes already written stay written.
- R7: `overflow_o` stays set until the next load starts or reset is asserted. Either one clears it.
- R8: An acknowledge that arrives with `rd_err_i` high ends the load as a failure. No further writes or reads follow, and `ready_o` rises.
- R9: `start_i` is ignored while a load is running. The running load is not restarted and carries on to its normal end.
- R10: A count of 0 gives a successful load with no configuration writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Reload request from the command controller |
| done_o | output | 1 | One-cycle pulse when a load ends |
| ready_o | output | 1 | Device ready; low while a load runs |
| loaded_o | output | 1 | Last load succeeded |
| overflow_o | output | 1 | Sticky flag: the record ran past the end of the memory |
| rd_req_o | output | 1 | Byte read request pulse |
| rd_addr_o | output | $clog2(MEM_BYTES) | Byte read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Read data |
| rd_err_i | input | 1 | Read failed or timed out (valid with rd_ack_i) |
| cfg_we_o | output | 1 | Configuration write strobe |
| cfg_addr_o | output | CFG_AW | Configuration target address |
| cfg_data_o | output | 8 | Configuration write data |

## Verification
Some properties are checked by assertions on every cycle:
- `ready_o` stays low whenever the controller is busy.
- Read requests never come two cycles in a row and never address beyond the memory.
- The overflow flag stays set except when a load starts.
- `loaded_o` can only rise together with `done_o`.
- A signature mismatch always returns the controller to idle with `loaded_o` clear.

Other behaviour only the bench scenarios can show, by comparing with a modelled memory image:
- the exact number, order and values of the configuration writes;
- where a load stops on an overflow or an injected read error;
- that a start during a load is ignored;
- that reset and a new load both clear a stale overflow.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIG_REQ,
    ST_SIG_WAIT,
    ST_LEN_REQ,
    ST_LEN_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT
  } ld_state_t;

  localparam logic [7:0] SIG_VALUE = 8'hA5;
endpackage

// File: rtl/cfg_loader_ptr.sv
// Memory byte pointer. It saturates one past the last address, so the
// controller can see the end of the memory before it issues a read.
module cfg_loader_ptr #(
  parameter int MEM_BYTES = 256,
  localparam int PW = $clog2(MEM_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [PW-1:0] ptr,
  output logic          at_end
);
  localparam logic [PW-1:0] LIMIT = PW'(MEM_BYTES);

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (inc && !at_end) ptr <= ptr + 1'b1;
  end

  assign at_end = (ptr == LIMIT);

  // R6: the pointer never goes past one beyond the last address
  a_r6_ptr_bounded: assert property (@(posedge clk) disable iff (rst)
    ptr <= LIMIT);
endmodule

// File: rtl/cfg_loader_emit.sv
// Registered output stage for the configuration writes.
module cfg_loader_emit #(
  parameter int CFG_AW = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic              we_o,
  output logic [CFG_AW-1:0] addr_o,
  output logic [7:0]        data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= fire;
      if (fire) begin
        addr_o <= CFG_AW'(idx);
        data_o <= data;
      end
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int CFG_AW    = 8,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(MEM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              done_o,
  output logic              ready_o,
  output logic              loaded_o,
  output logic              overflow_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_err_i,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [7:0]        cfg_data_o
);
  ld_state_t     state;
  logic          boot_q;
  logic [7:0]    cnt, idx;
  logic [PW-1:0] ptr;
  logic          at_end, go, req_st, wait_st, fire, ptr_inc;

  assign go      = (state == ST_IDLE) && (start_i || boot_q);
  assign req_st  = (state == ST_SIG_REQ) || (state == ST_LEN_REQ) || (state == ST_DAT_REQ);
  assign wait_st = (state == ST_SIG_WAIT) || (state == ST_LEN_WAIT) || (state == ST_DAT_WAIT);
  assign ptr_inc = wait_st && rd_ack_i;
  assign fire    = (state == ST_DAT_WAIT) && rd_ack_i && !rd_err_i;

  assign rd_req_o  = req_st && !at_end;
  assign rd_addr_o = ptr[AW-1:0];

  cfg_loader_ptr #(.MEM_BYTES(MEM_BYTES)) u_ptr (
    .clk(clk), .rst(rst), .clr(go), .inc(ptr_inc), .ptr(ptr), .at_end(at_end)
  );

  cfg_loader_emit #(.CFG_AW(CFG_AW), .IDX_W(8)) u_emit (
    .clk(clk), .rst(rst), .fire(fire), .idx(idx), .data(rd_data_i),
    .we_o(cfg_we_o), .addr_o(cfg_addr_o), .data_o(cfg_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      boot_q     <= 1'b1;
      ready_o    <= 1'b0;
      done_o     <= 1'b0;
      loaded_o   <= 1'b0;
      overflow_o <= 1'b0;
      cnt        <= '0;
      idx        <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          state      <= ST_SIG_REQ;
          boot_q     <= 1'b0;
          ready_o    <= 1'b0;
          loaded_o   <= 1'b0;
          overflow_o <= 1'b0;
          idx        <= '0;
        end
        ST_SIG_REQ, ST_LEN_REQ, ST_DAT_REQ: begin
          if (at_end) begin
            overflow_o <= 1'b1;
            state      <= ST_IDLE;
            ready_o    <= 1'b1;
            done_o     <= 1'b1;
          end else begin
            state <= ld_state_t'(state + 3'd1);
          end
        end
        ST_SIG_WAIT: if (rd_ack_i) begin
          if (rd_err_i || rd_data_i != SIG_VALUE) begin
            state   <= ST_IDLE;
            ready_o <= 1'b1;
            done_o  <= 1'b1;
          end else begin
            state <= ST_LEN_REQ;
          end
        end
        ST_LEN_WAIT: if (rd_ack_i) begin
          if (rd_err_i || rd_data_i == 8'd0) begin
            state    <= ST_IDLE;
            ready_o  <= 1'b1;
            done_o   <= 1'b1;
            loaded_o <= !rd_err_i;
          end else begin
            cnt   <= rd_data_i;
            state <= ST_DAT_REQ;
          end
        end
        ST_DAT_WAIT: if (rd_ack_i) begin
          if (rd_err_i || idx == cnt - 8'd1) begin
            state    <= ST_IDLE;
            ready_o  <= 1'b1;
            done_o   <= 1'b1;
            loaded_o <= !rd_err_i;
          end else begin
            state <= ST_DAT_REQ;
          end
          idx <= idx + 8'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: ready stays low while a load is in progress
  a_r1_not_ready_busy: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !ready_o);

  // R2: read requests are single-cycle pulses
  a_r2_single_req: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);

  // R3: a signature mismatch ends the load, not loaded
  a_r3_bad_sig_fails: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SIG_WAIT && rd_ack_i && rd_data_i != SIG_VALUE)
      |=> (state == ST_IDLE && !loaded_o));

  // R4: each configuration write follows a read response
  a_r4_write_after_ack: assert property (@(posedge clk) disable iff (rst)
    cfg_we_o |-> $past(rd_ack_i));

  // R5: loaded rises only at the end of a load
  a_r5_loaded_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded_o) |-> done_o);

  // R6: no read beyond the last memory address
  a_r6_no_read_past_end: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (ptr < PW'(MEM_BYTES)));

  // R7: overflow is sticky until a new load starts
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !go) |=> overflow_o);
endmodule

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;
  localparam int MEM = 16;
  localparam int AW  = $clog2(MEM);
  localparam int MAXN = MEM - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic done_o, ready_o, loaded_o, overflow_o, rd_req_o, cfg_we_o;
  logic [AW-1:0] rd_addr_o;
  logic rd_ack_i = 1'b0, rd_err_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic [7:0] cfg_addr_o, cfg_data_o;

  always #2.5 clk = ~clk;

  cfg_loader #(.MEM_BYTES(MEM), .CFG_AW(8)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o), .ready_o(ready_o),
    .loaded_o(loaded_o), .overflow_o(overflow_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .rd_err_i(rd_err_i), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
    .cfg_data_o(cfg_data_o)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] mem [MEM];
  int lat = 1, cd = 0, err_addr = -1, exp_rd = 0, seq_err = 0, n_reads = 0;
  int pend_addr = 0;
  int wr_n = 0, done_n = 0, cyc = 0;
  logic [7:0] wr_data [64];
  logic [7:0] wr_addr [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    rd_ack_i <= 1'b0;
    rd_err_i <= 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= mem[pend_addr];
        rd_err_i  <= (pend_addr == err_addr);
      end
    end
    if (rd_req_o) begin
      if (int'(rd_addr_o) != exp_rd) seq_err++;
      exp_rd++;
      n_reads++;
      pend_addr = int'(rd_addr_o);
      cd = lat;
    end
    if (cfg_we_o && wr_n < 64) begin
      wr_data[wr_n] = cfg_data_o;
      wr_addr[wr_n] = cfg_addr_o;
      wr_n++;
    end
    if (done_o) done_n++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic build(input logic [7:0] sig, input logic [7:0] len, input int seed);
    mem[0] = sig;
    mem[1] = len;
    for (int i = 2; i < MEM; i++) mem[i] = 8'((i * 37 + seed * 11) & 8'hFF);
  endtask

  task automatic clear_obs();
    wr_n = 0; exp_rd = 0; seq_err = 0; n_reads = 0;
  endtask

  task automatic wait_done(input int d0);
    int t = 0;
    while (done_n == d0 && t < 2000) begin @(negedge clk); t++; end
    check(done_n != d0, "R1 done pulse", done_n - d0, 1);
  endtask

  task automatic run_load();
    int d0;
    clear_obs();
    d0 = done_n;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(ready_o == 1'b0, "R1 ready low while loading", ready_o, 0);
    wait_done(d0);
    @(negedge clk);
  endtask

  task automatic verify(input string tag, input int exp_n, input bit exp_ld, input bit exp_ov);
    bit dok = 1'b1;
    check(wr_n == exp_n, {tag, " R4 write count"}, wr_n, exp_n);
    for (int k = 0; k < exp_n && k < wr_n; k++)
      if (wr_data[k] != mem[k + 2] || wr_addr[k] != 8'(k)) dok = 1'b0;
    check(dok, {tag, " R4 write data/address"}, int'(dok), 1);
    check(loaded_o == exp_ld, {tag, " R5 loaded"}, loaded_o, exp_ld);
    check(overflow_o == exp_ov, {tag, " R6 overflow"}, overflow_o, exp_ov);
    check(ready_o == 1'b1, {tag, " R1 ready after load"}, ready_o, 1);
    check(seq_err == 0, {tag, " R2 read address order"}, seq_err, 0);
  endtask

  initial begin
    int d0;
    build(8'hA5, 8'd5, 1);
    clear_obs();
    repeat (4) @(negedge clk);
    check(ready_o == 0 && loaded_o == 0 && overflow_o == 0 && cfg_we_o == 0,
          "R1 reset state", {ready_o, loaded_o, overflow_o, cfg_we_o}, 0);
    d0 = done_n;
    rst = 1'b0;
    @(negedge clk);
    check(ready_o == 1'b0, "R1 ready low during boot load", ready_o, 0);
    wait_done(d0);
    @(negedge clk);
    verify("boot R1", 5, 1'b1, 1'b0);

    // sweep: latency x length, R4 R5 R6 R10
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      for (int n = 0; n <= MAXN + 6; n++) begin
        build(8'hA5, 8'(n), n + l);
        run_load();
        verify(n == 0 ? "R10 zero length" : "sweep", (n > MAXN) ? MAXN : n,
               n <= MAXN, n > MAXN);
        check(n_reads == ((n > MAXN) ? MEM : n + 2), "R2 read count", n_reads,
              (n > MAXN) ? MEM : n + 2);
      end
    end

    // R7 sticky overflow, then cleared by new load
    lat = 1;
    build(8'hA5, 8'd40, 3);
    run_load();
    repeat (10) @(negedge clk);
    check(overflow_o == 1'b1, "R7 overflow sticky while idle", overflow_o, 1);
    build(8'h00, 8'd2, 3);
    run_load();
    check(overflow_o == 1'b0, "R7 overflow cleared by new load", overflow_o, 1'b0);

    // R3 every wrong signature value
    for (int s = 0; s < 256; s++) begin
      if (s == 8'hA5) continue;
      build(8'(s), 8'd3, s);
      run_load();
      check(wr_n == 0 && loaded_o == 0, "R3 bad signature no load", wr_n, 0);
      check(n_reads == 1, "R3 single read on bad signature", n_reads, 1);
    end

    // R8 read error at each address
    for (int ea = 0; ea < 8; ea++) begin
      lat = 2;
      err_addr = ea;
      build(8'hA5, 8'd6, ea);
      run_load();
      verify("R8 read error", (ea >= 2) ? ea - 2 : 0, 1'b0, 1'b0);
      check(n_reads == ea + 1, "R8 no reads after error", n_reads, ea + 1);
    end
    err_addr = -1;

    // R9 start while busy ignored
    lat = 3;
    build(8'hA5, 8'd10, 7);
    clear_obs();
    d0 = done_n;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done(d0);
    @(negedge clk);
    verify("R9 start while busy", 10, 1'b1, 1'b0);
    check(done_n == d0 + 1, "R9 single completion", done_n - d0, 1);

    // R7 reset clears overflow, then boot load runs again
    lat = 1;
    build(8'hA5, 8'd30, 2);
    run_load();
    check(overflow_o == 1'b1, "R6 overflow set", overflow_o, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(overflow_o == 1'b0, "R7 overflow cleared by reset", overflow_o, 0);
    build(8'hA5, 8'd4, 9);
    clear_obs();
    d0 = done_n;
    rst = 1'b0;
    wait_done(d0);
    @(negedge clk);
    verify("R1 reload after reset", 4, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule